// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This combinational block shifts a signed fixed-point word either left or right by a signed count, in one of two operand widths. A narrow mode treats the low 16 bits of the operand as a signed value and returns a sign-extended 32-bit result. A wide mode treats all 32 bits as the signed value. A left shift that would lose significant bits clamps to the largest positive or most negative value of the selected width and raises an overflow flag.

A count with its sign bit set reverses the requested direction, and its magnitude sets the shift distance. This lets a datapath feed a signed exponent straight in without a separate compare-and-negate stage. Right shifts are arithmetic. When the rounding input is set, a right shift adds back the last bit shifted out, which gives round-half-up behaviour. The result is a pure function of the present inputs: there are no registers and no handshake.

Top module: `sat_bishift`

## Requirements
- R1: The effective direction is right when `i_dir_right` differs from the sign bit of `i_count`, and left otherwise. The shift distance is the magnitude of `i_count`. The count -32768 gives a distance of 32768 in the reversed direction.
- R2: When `i_wide` is 0, only `i_operand[15:0]` is used, as a signed 16-bit value, and bits 31:16 have no effect. `o_result` is the 16-bit result sign-extended to 32 bits.
- R3: In narrow mode, a left shift of a nonzero operand saturates when the distance is above 15 or the exact result falls outside the signed 16-bit range. The output is then 0x00007FFF for a positive operand and 0xFFFF8000 for a negative one.
- R4: In wide mode, a left shift of a nonzero operand saturates when the exact result falls outside the signed 32-bit range, which includes every distance of 32 or more. The output is then 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one.
- R5: A left shift that does not saturate returns the operand times two to the power of the distance, exactly. A zero operand never saturates and always returns 0.
- R6: A right shift without rounding returns the floor of the operand divided by two to the power of the distance. Any distance of at least the width minus one gives -1 for a negative operand and 0 otherwise.
- R7: With `i_round` set, a right shift with a distance from 1 to the width minus one adds the operand bit at position (distance - 1) to the result of R6.
- R8: With `i_round` set, a right shift with a distance greater than the width minus one (15 narrow, 31 wide) returns 0.
- R9: `o_ovf` is 1 exactly when a left shift saturates. A distance of zero returns the operand unchanged in either direction, whatever the state of `i_round`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_operand | input | 32 | Signed operand; only the low 16 bits are used in narrow mode |
| i_count | input | 16 | Signed shift count; a negative count reverses the direction |
| i_wide | input | 1 | 1 selects the 32-bit width, 0 selects the 16-bit width |
| i_dir_right | input | 1 | Requested direction: 1 shifts right, 0 shifts left |
| i_round | input | 1 | Round right shifts by adding the last bit shifted out |
| o_result | output | 32 | Shifted result, sign-extended in narrow mode |
| o_ovf | output | 1 | High when a left shift saturated |

## Verification
The bench builds the shifter with its default parameters: a 16-bit narrow width, a 32-bit wide width and a 16-bit count. With a 16-bit count, the bench can apply the most negative count and distances far beyond either operand width. It can therefore reach the distance clamps on both sides, the reversal of -32768 and the far-distance rounding case. Random operands in narrow mode carry random upper bits, which shows that those bits are ignored. Random counts are weighted toward the region around the saturation and sign-fill thresholds, so that the boundaries between neighbouring distances are exercised often.

// File: rtl/sat_bishift.sv
module sat_bishift #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int CNT_W    = 16
) (
  input  logic [WIDE_W-1:0] i_operand,
  input  logic [CNT_W-1:0]  i_count,
  input  logic              i_wide,
  input  logic              i_dir_right,
  input  logic              i_round,
  output logic [WIDE_W-1:0] o_result,
  output logic              o_ovf
);

  localparam int MAG_W = CNT_W + 1;
  localparam int SH_W  = $clog2(WIDE_W);
  localparam int GAP   = WIDE_W - NARROW_W;

  logic signed [WIDE_W-1:0] val;
  logic [MAG_W-1:0]         cnt_x, mag, lim;
  logic                     eff_right, is_zero, left_ovf, rbit, right_far;
  logic [SH_W-1:0]          norm, headroom, rsh, idx;
  logic [WIDE_W-1:0]        pos_sat, neg_sat, left_val, right_val;
  logic signed [WIDE_W-1:0] shr_val;

  assign val = i_wide ? i_operand
                      : {{GAP{i_operand[NARROW_W-1]}}, i_operand[NARROW_W-1:0]};

  assign cnt_x     = {i_count[CNT_W-1], i_count};
  assign mag       = i_count[CNT_W-1] ? (~cnt_x + MAG_W'(1)) : cnt_x;
  assign eff_right = i_dir_right ^ i_count[CNT_W-1];
  assign lim       = i_wide ? MAG_W'(WIDE_W - 1) : MAG_W'(NARROW_W - 1);
  assign is_zero   = (val == '0);

  always_comb begin
    logic run;
    norm = '0;
    run  = 1'b1;
    for (int b = WIDE_W - 2; b >= 0; b--) begin
      if (run && (val[b] == val[WIDE_W-1])) norm = norm + SH_W'(1);
      else run = 1'b0;
    end
  end

  assign headroom = norm - (i_wide ? SH_W'(0) : SH_W'(GAP));
  assign left_ovf = !is_zero && (mag > MAG_W'(headroom));
  assign left_val = val << mag[SH_W-1:0];
  assign pos_sat  = i_wide ? {1'b0, {(WIDE_W-1){1'b1}}}
                           : {{(GAP+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  assign neg_sat  = ~pos_sat;

  assign rsh       = (mag > MAG_W'(WIDE_W - 1)) ? SH_W'(WIDE_W - 1) : mag[SH_W-1:0];
  assign shr_val   = val >>> rsh;
  assign idx       = mag[SH_W-1:0] - SH_W'(1);
  assign right_far = mag > lim;
  assign rbit      = (mag != '0) && !right_far && val[idx];
  assign right_val = (i_round && right_far) ? '0
                   : shr_val + (i_round ? WIDE_W'(rbit) : WIDE_W'(0));

  assign o_result = eff_right ? right_val
                  : (left_ovf ? (val[WIDE_W-1] ? neg_sat : pos_sat) : left_val);
  assign o_ovf    = !eff_right && left_ovf;

  always_comb begin
    if (!i_wide)
      AST_NARROW_SEXT: assert (o_result[WIDE_W-1:NARROW_W-1] == '0 ||
                               o_result[WIDE_W-1:NARROW_W-1] == '1); // R2
    if (o_ovf)
      AST_SAT_SIGN: assert (o_result[WIDE_W-1] == val[WIDE_W-1]); // R3
    if (is_zero)
      AST_ZERO_IN_ZERO_OUT: assert (o_result == '0 && !o_ovf); // R5
    if (eff_right && !i_round)
      AST_RIGHT_KEEPS_SIGN: assert (o_result[WIDE_W-1] == val[WIDE_W-1]); // R6
    if (mag == '0)
      AST_NO_DISTANCE_PASS: assert (o_result == val && !o_ovf); // R9
  end

endmodule

// File: tb/sim_sat_bishift.sv
`timescale 1ns/1ps
module sim_sat_bishift;

  logic        clk = 1'b0;
  logic [31:0] op;
  logic [15:0] cnt;
  logic        wide, right, rnd;
  logic [31:0] res;
  logic        ovf;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sat_bishift u0 (
    .i_operand(op), .i_count(cnt), .i_wide(wide), .i_dir_right(right),
    .i_round(rnd), .o_result(res), .o_ovf(ovf)
  );

  function automatic logic [32:0] model(logic [31:0] x, logic signed [15:0] c,
                                        logic wd, logic rt, logic rd);
    int     w;
    longint xs, m, mx, mn, r, p;
    logic   effr, ov;
    w    = wd ? 32 : 16;
    xs   = wd ? longint'($signed(x)) : longint'($signed(x[15:0]));
    m    = (c < 0) ? -longint'(c) : longint'(c);
    effr = rt ^ (c < 0);
    mx   = (longint'(1) <<< (w - 1)) - 1;
    mn   = -mx - 1;
    ov   = 1'b0;
    if (!effr) begin
      if (xs == 0) r = 0;
      else if (m >= w) begin ov = 1'b1; r = (xs > 0) ? mx : mn; end
      else begin
        p = xs * (longint'(1) <<< m);
        if (p > mx || p < mn) begin ov = 1'b1; r = (xs > 0) ? mx : mn; end
        else r = p;
      end
    end else begin
      if (rd && m > w - 1) r = 0;
      else begin
        r = xs >>> ((m > 62) ? 62 : m);
        if (rd && m > 0) r = r + ((xs >>> (m - 1)) & 1);
      end
    end
    return {ov, r[31:0]};
  endfunction

  task automatic apply(logic [31:0] x, logic [15:0] c, logic wd, logic rt,
                       logic rd, string tag);
    logic [32:0] e;
    @(posedge clk);
    op = x; cnt = c; wide = wd; right = rt; rnd = rd;
    @(negedge clk);
    e = model(x, c, wd, rt, rd);
    n_chk++;
    if (res !== e[31:0] || ovf !== e[32]) begin
      n_fail++;
      $display("FAIL %s: op=%h cnt=%0d wide=%b right=%b round=%b got %h/%b expected %h/%b",
               tag, x, $signed(c), wd, rt, rd, res, ovf, e[31:0], e[32]);
    end
  endtask

  function automatic string pick_tag(logic [31:0] x, logic [15:0] c,
                                     logic wd, logic rt, logic rd);
    logic [32:0] e;
    logic effr;
    e = model(x, c, wd, rt, rd);
    effr = rt ^ c[15];
    if (!effr) return e[32] ? (wd ? "R4" : "R3") : "R5";
    if (rd) return "R7";
    return "R6";
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    op = '0; cnt = '0; wide = 0; right = 0; rnd = 0;
    apply(32'h0, 16'd0, 0, 0, 0, "R9 idle");
    apply(32'h1234_5678, 16'd0, 1, 1, 1, "R9 zero distance right round");
    apply(32'hFFFF_8001, 16'd0, 0, 0, 1, "R9 zero distance left");
    apply(32'h0000_0003, 16'hFFFE, 1, 1, 0, "R1 negative count on right gives left");
    apply(32'h0000_0040, 16'hFFFD, 1, 0, 0, "R1 negative count on left gives right");
    apply(32'h0000_0001, 16'h8000, 1, 1, 0, "R1 most negative count reversed");
    apply(32'h8000_0000, 16'h8000, 1, 0, 1, "R8 most negative count far round");
    apply(32'hABCD_4000, 16'd1, 0, 0, 0, "R2 upper bits ignored");
    apply(32'h0000_4000, 16'd1, 0, 0, 0, "R3 narrow just over");
    apply(32'h0000_8000, 16'd1, 0, 0, 0, "R3 narrow negative");
    apply(32'h0000_0001, 16'd16, 0, 0, 0, "R3 narrow distance 16");
    apply(32'h0000_FFFF, 16'd15, 0, 0, 0, "R5 narrow -1 by 15 fits");
    apply(32'h0000_0001, 16'd14, 0, 0, 0, "R5 narrow fits top");
    apply(32'h4000_0000, 16'd1, 1, 0, 0, "R4 wide just over");
    apply(32'h3FFF_FFFF, 16'd1, 1, 0, 0, "R5 wide just fits");
    apply(32'hC000_0000, 16'd1, 1, 0, 0, "R5 wide negative fits");
    apply(32'hBFFF_FFFF, 16'd1, 1, 0, 0, "R4 wide negative over");
    apply(32'h0000_0000, 16'd300, 1, 0, 0, "R5 zero never saturates");
    apply(32'h0000_8000, 16'd15, 0, 1, 0, "R6 narrow sign fill");
    apply(32'h8000_0000, 16'd40, 1, 1, 0, "R6 wide far fill");
    apply(32'h0000_0005, 16'd1, 1, 1, 1, "R7 round up");
    apply(32'hFFFF_FFFB, 16'd1, 1, 1, 1, "R7 round negative");
    apply(32'h0000_FFFF, 16'd15, 0, 1, 1, "R7 narrow edge");
    apply(32'h0000_7FFF, 16'd16, 0, 1, 1, "R8 narrow far round");
    apply(32'hFFFF_FFFF, 16'd32, 1, 1, 1, "R8 wide far round");
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x;
      logic [15:0] c;
      logic wd, rt, rd;
      x  = $urandom;
      if ($urandom_range(3) == 0) x = 32'(x >>> $urandom_range(31));
      wd = $urandom_range(1);
      rt = $urandom_range(1);
      rd = $urandom_range(1);
      if ($urandom_range(4) == 0) c = $urandom;
      else c = 16'($signed($urandom_range(80)) - 40);
      apply(x, c, wd, rt, rd, pick_tag(x, c, wd, rt, rd));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule